// File: doc/BRIEF.md
# Readout Window Track Selector

This block sits after the stage that builds combined track records. Each record arrives with a valid strobe, a time-bin number and a data payload. The block forwards a record only when its bin falls inside a readout window centred on bin 8. The window width is configurable to 3, 5 or 7 bins. The block also caps how many records are forwarded from any one bin within an event.

An event begins with a one-cycle `evt_start` pulse. The pulse may coincide with the first record of the new event. Within an event, records must arrive in non-decreasing bin order. In the optional earliest-pair mode, only the first two in-window records of the event are forwarded. Records that fall outside the window are counted. An unsupported window size is replaced by the widest window and raises a configuration-error flag.

Top module: `rdo_window_sel`

## Requirements
- R1: After reset, `out_valid` is 0, `drop_cnt` is 0 and `cfg_err` is 0.
- R2: A record whose bin lies in [8 - size/2, 8 - size/2 + size - 1] (integer division) is forwarded one cycle later. On that cycle `out_valid` is 1 and `out_bin` and `out_data` equal the input values. Size 7 accepts bins 5..11, size 5 accepts bins 6..10 and size 3 accepts bins 7..9.
- R3: Any `cfg_win_size` value other than 3, 5 or 7 acts as size 7. In that case `cfg_err` reads 1 on the cycle after the value is presented, and 0 otherwise.
- R4: Within one event, at most two records of the same bin are forwarded. Later records of that bin are discarded and do not change `drop_cnt`.
- R5: When `cfg_earliest2` is 1, only the first two in-window records of the event are forwarded. Later ones are discarded and do not change `drop_cnt`.
- R6: Each valid record outside the window raises `drop_cnt` by 1 on the next cycle. The count saturates at 2^DROP_W - 1.
- R7: `evt_start` clears the per-bin and per-event counts. A record presented in the same cycle is counted as the first record of the new event.
- R8: A cycle with `in_valid` at 0 gives `out_valid` 0 on the next cycle and leaves `drop_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | First cycle of a new event |
| in_valid | input | 1 | Record present |
| in_bin | input | BIN_W | Time bin of the record |
| in_data | input | DATA_W | Record payload |
| cfg_win_size | input | 3 | Window width in bins (3, 5 or 7) |
| cfg_earliest2 | input | 1 | Forward only the first two in-window records per event |
| out_valid | output | 1 | Forwarded record present |
| out_bin | output | BIN_W | Time bin of the forwarded record |
| out_data | output | DATA_W | Payload of the forwarded record |
| drop_cnt | output | DROP_W | Saturating count of out-of-window records |
| cfg_err | output | 1 | Last window size presented was unsupported |

## Verification
An event restart and a record acceptance can land on the same cycle. In that cycle the counters must clear and the incoming record must also be counted. The stimulus table raises `evt_start` together with a record in a bin that has already reached its cap. It does this in both modes and also for an earliest-pair quota that is full. The record must be forwarded, and the next two records of that bin must behave as the second and third of a fresh event. A second overlap happens when an out-of-window drop meets a full quota. That record must still increment `drop_cnt`, while capped in-window records must leave it unchanged.

// File: rtl/rdo_window_sel.sv
module rdo_window_sel #(
  parameter int BIN_W  = 4,
  parameter int DATA_W = 16,
  parameter int DROP_W = 8,
  parameter int CENTER = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_start,
  input  logic              in_valid,
  input  logic [BIN_W-1:0]  in_bin,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        cfg_win_size,
  input  logic              cfg_earliest2,
  output logic              out_valid,
  output logic [BIN_W-1:0]  out_bin,
  output logic [DATA_W-1:0] out_data,
  output logic [DROP_W-1:0] drop_cnt,
  output logic              cfg_err
);
  localparam int NBINS = 1 << BIN_W;
  localparam int LW    = BIN_W + 1;
  localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

  logic            size_ok;
  logic [2:0]      size_eff;
  logic [LW-1:0]   lo, hi, bin_x;
  logic            in_win;
  logic [1:0]      bcnt [NBINS];
  logic [1:0]      bin_eff, tot, tot_eff;
  logic            accept;

  assign size_ok  = (cfg_win_size == 3'd3) || (cfg_win_size == 3'd5) || (cfg_win_size == 3'd7);
  assign size_eff = size_ok ? cfg_win_size : 3'd7;
  assign lo       = LW'(CENTER) - LW'(size_eff >> 1);
  assign hi       = lo + LW'(size_eff) - LW'(1);
  assign bin_x    = {1'b0, in_bin};
  assign in_win   = (bin_x >= lo) && (bin_x <= hi);

  assign bin_eff = evt_start ? 2'd0 : bcnt[in_bin];
  assign tot_eff = evt_start ? 2'd0 : tot;
  assign accept  = in_valid && in_win && (bin_eff < 2'd2) &&
                   (!cfg_earliest2 || (tot_eff < 2'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBINS; b++) bcnt[b] <= 2'd0;
      tot <= 2'd0;
    end else begin
      for (int b = 0; b < NBINS; b++) begin
        if (accept && (in_bin == BIN_W'(b)))
          bcnt[b] <= bin_eff + 2'd1;
        else if (evt_start)
          bcnt[b] <= 2'd0;
      end
      if (accept && (tot_eff < 2'd2))
        tot <= tot_eff + 2'd1;
      else
        tot <= tot_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_data  <= '0;
      drop_cnt  <= '0;
      cfg_err   <= 1'b0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_bin  <= in_bin;
        out_data <= in_data;
      end
      if (in_valid && !in_win && (drop_cnt != DROP_MAX))
        drop_cnt <= drop_cnt + DROP_W'(1);
      cfg_err <= !size_ok;
    end
  end
endmodule

// File: rtl/rdo_window_chk.sv
module rdo_window_chk #(
  parameter int BIN_W  = 4,
  parameter int DROP_W = 8,
  parameter int CENTER = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        cfg_win_size,
  input logic              out_valid,
  input logic [BIN_W-1:0]  out_bin,
  input logic [DROP_W-1:0] drop_cnt,
  input logic              cfg_err
);
  function automatic int win_lo(input logic [2:0] s);
    int w;
    w = (s == 3'd3 || s == 3'd5) ? int'(s) : 7;
    return CENTER - w / 2;
  endfunction

  function automatic int win_hi(input logic [2:0] s);
    int w;
    w = (s == 3'd3 || s == 3'd5) ? int'(s) : 7;
    return CENTER - w / 2 + w - 1;
  endfunction

  p_out_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_bin) >= win_lo($past(cfg_win_size)) &&
                   int'(out_bin) <= win_hi($past(cfg_win_size))));

  p_out_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_cfg_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cfg_err == !($past(cfg_win_size) inside {3'd3, 3'd5, 3'd7})));

  p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(drop_cnt)));
endmodule

bind rdo_window_sel rdo_window_chk #(.BIN_W(BIN_W), .DROP_W(DROP_W), .CENTER(CENTER)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_win_size(cfg_win_size),
  .out_valid(out_valid), .out_bin(out_bin), .drop_cnt(drop_cnt), .cfg_err(cfg_err)
);

// File: tb/sim_rdo_window_sel.sv
`timescale 1ns/1ps
module sim_rdo_window_sel;
  localparam int BIN_W = 4, DATA_W = 16, DROP_W = 4;
  localparam int NV = 30;
  // {evt, valid, bin[3:0], size[2:0], earliest2, expect_forward, expect_drop}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1,1'b1,4'd5, 3'd7,1'b0,1'b1,1'b0},  // 0  R2 low edge of 7
    {1'b0,1'b1,4'd4, 3'd7,1'b0,1'b0,1'b1},  // 1  R6 below
    {1'b0,1'b1,4'd11,3'd7,1'b0,1'b1,1'b0},  // 2  R2 high edge
    {1'b0,1'b1,4'd12,3'd7,1'b0,1'b0,1'b1},  // 3  R6 above
    {1'b0,1'b1,4'd11,3'd7,1'b0,1'b1,1'b0},  // 4  R4 second in bin
    {1'b0,1'b1,4'd11,3'd7,1'b0,1'b0,1'b0},  // 5  R4 third capped
    {1'b0,1'b0,4'd8, 3'd7,1'b0,1'b0,1'b0},  // 6  R8 idle
    {1'b1,1'b1,4'd5, 3'd5,1'b0,1'b0,1'b1},  // 7  R2 size 5
    {1'b0,1'b1,4'd6, 3'd5,1'b0,1'b1,1'b0},  // 8
    {1'b0,1'b1,4'd10,3'd5,1'b0,1'b1,1'b0},  // 9
    {1'b0,1'b1,4'd11,3'd5,1'b0,1'b0,1'b1},  // 10
    {1'b1,1'b1,4'd7, 3'd3,1'b0,1'b1,1'b0},  // 11 R2 size 3
    {1'b0,1'b1,4'd9, 3'd3,1'b0,1'b1,1'b0},  // 12
    {1'b0,1'b1,4'd6, 3'd3,1'b0,1'b0,1'b1},  // 13
    {1'b0,1'b1,4'd10,3'd3,1'b0,1'b0,1'b1},  // 14
    {1'b1,1'b1,4'd5, 3'd4,1'b0,1'b1,1'b0},  // 15 R3 clamp
    {1'b0,1'b1,4'd11,3'd6,1'b0,1'b1,1'b0},  // 16 R3
    {1'b0,1'b1,4'd4, 3'd0,1'b0,1'b0,1'b1},  // 17 R3
    {1'b1,1'b1,4'd3, 3'd7,1'b1,1'b0,1'b1},  // 18 R5
    {1'b0,1'b1,4'd5, 3'd7,1'b1,1'b1,1'b0},  // 19
    {1'b0,1'b1,4'd6, 3'd7,1'b1,1'b1,1'b0},  // 20
    {1'b0,1'b1,4'd7, 3'd7,1'b1,1'b0,1'b0},  // 21 R5 quota full
    {1'b0,1'b1,4'd12,3'd7,1'b1,1'b0,1'b1},  // 22 R6 drop with full quota
    {1'b1,1'b1,4'd7, 3'd7,1'b1,1'b1,1'b0},  // 23 R7 restart clears quota
    {1'b0,1'b1,4'd7, 3'd7,1'b1,1'b1,1'b0},  // 24
    {1'b0,1'b1,4'd7, 3'd7,1'b1,1'b0,1'b0},  // 25
    {1'b1,1'b1,4'd7, 3'd7,1'b0,1'b1,1'b0},  // 26 R7 restart on capped bin
    {1'b1,1'b1,4'd7, 3'd7,1'b0,1'b1,1'b0},  // 27 R7 again
    {1'b0,1'b1,4'd7, 3'd7,1'b0,1'b1,1'b0},  // 28
    {1'b0,1'b1,4'd7, 3'd7,1'b0,1'b0,1'b0}   // 29 R4
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_start = 1'b0, in_valid = 1'b0, cfg_earliest2 = 1'b0;
  logic [BIN_W-1:0] in_bin = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic [2:0] cfg_win_size = 3'd7;
  logic out_valid, cfg_err;
  logic [BIN_W-1:0] out_bin;
  logic [DATA_W-1:0] out_data;
  logic [DROP_W-1:0] drop_cnt;
  int checks = 0, fails = 0;
  int exp_drop = 0;

  always #2 clk = ~clk;

  rdo_window_sel #(.BIN_W(BIN_W), .DATA_W(DATA_W), .DROP_W(DROP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .in_valid(in_valid),
    .in_bin(in_bin), .in_data(in_data), .cfg_win_size(cfg_win_size),
    .cfg_earliest2(cfg_earliest2), .out_valid(out_valid), .out_bin(out_bin),
    .out_data(out_data), .drop_cnt(drop_cnt), .cfg_err(cfg_err));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic e, input logic v, input logic [3:0] b,
                       input logic [2:0] s, input logic m, input logic [DATA_W-1:0] d);
    @(negedge clk);
    evt_start = e; in_valid = v; in_bin = b; cfg_win_size = s;
    cfg_earliest2 = m; in_data = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 drop_cnt", int'(drop_cnt), 0);
    check("R1 cfg_err", int'(cfg_err), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v;
      logic [DATA_W-1:0] d;
      v = VEC[i];
      d = DATA_W'(i * 97 + 13);
      apply(v[11], v[10], v[9:6], v[5:3], v[2], d);
      if (v[0] && exp_drop < 15) exp_drop++;
      check($sformatf("R2/R4/R5/R7 forward vec %0d", i), int'(out_valid), int'(v[1]));
      if (v[1]) begin
        check($sformatf("R2 bin vec %0d", i), int'(out_bin), int'(v[9:6]));
        check($sformatf("R2 data vec %0d", i), int'(out_data), int'(d));
      end
      check($sformatf("R6 drop vec %0d", i), int'(drop_cnt), exp_drop);
      check($sformatf("R3 cfg_err vec %0d", i), int'(cfg_err),
            int'(!(v[5:3] inside {3'd3, 3'd5, 3'd7})));
    end

    // R8: idle cycle after traffic
    apply(1'b0, 1'b0, 4'd12, 3'd7, 1'b0, '0);
    check("R8 idle out_valid", int'(out_valid), 0);
    check("R8 idle drop_cnt", int'(drop_cnt), exp_drop);

    // R6: saturation of the drop counter
    for (int k = 0; k < 10; k++) begin
      apply(1'b0, 1'b1, 4'd0, 3'd3, 1'b0, '0);
      if (exp_drop < 15) exp_drop++;
    end
    check("R6 saturated", int'(drop_cnt), 15);
    apply(1'b0, 1'b1, 4'd15, 3'd7, 1'b0, '0);
    check("R6 stays saturated", int'(drop_cnt), 15);

    // R1: reset mid-run restores reset state
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; cfg_win_size = 3'd2;
    @(posedge clk); #1;
    check("R1 reset drop_cnt", int'(drop_cnt), 0);
    check("R1 reset cfg_err", int'(cfg_err), 0);
    check("R1 reset out_valid", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R3 cfg_err after reset", int'(cfg_err), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule